// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 128K words by 8 bits. The requester presents a read or write over a valid/ready port. The controller then sequences the memory's two chip selects, write enable, output enable, address bus and split data bus. It returns read data with a single-cycle valid pulse.

The memory has no clock, so every timing minimum is met by holding the pins for a whole number of system-clock cycles. Each count is the ceiling of a nanosecond figure, taken for the selected speed grade, divided by the clock-period parameter. Between accesses the bus is parked deselected with the data drivers off. A retention input keeps it parked for as long as the memory supply may be lowered. After release, a full cycle time passes before a new request is taken.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and after it, all memory pins are parked and `rsp_valid` is 0. Parked means `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. `req_ready` stays 0 for exactly one cycle-time count of cycles, counted from the cycle in which reset is released.
- R2: Each pin count is the ceiling of the grade's nanosecond figure over `CLK_NS`, and is at least 1. For `CLK_NS`=8 and grade 0 the counts are: cycle time 7, write pulse 6 (the largest of write pulse, select/address-to-end-of-write and data overlap), read access 7 (the larger of address access and output-enable access), and bus turnaround 3.
- R3: An accepted read (`req_write`=0) drives both selects active, `mem_oe_n`=0 and `mem_we_n`=1, with the drivers off and `mem_addr` equal to the request address. This lasts for max(access, cycle time) cycles, starting in the cycle after acceptance.
- R4: Read data is sampled from `mem_dq_in` on the edge that ends the last output-enable cycle. `rsp_valid` is 1 for exactly one cycle after that edge, and `rsp_data` carries the sampled byte.
- R5: An accepted write holds `mem_oe_n`=1 and drives `mem_dq_out` with the request data, with `mem_dq_oe`=1, for max(cycle time, pulse+1) cycles. `mem_we_n` is low for exactly the write-pulse count, starting in the first of those cycles. Address and data stay stable while it is low and for one cycle after it rises.
- R6: After a read, the controller waits the turnaround count with selects and output enable released before it accepts anything. Its drivers never turn on within that count of `mem_oe_n` rising.
- R7: `req_ready` falls in the cycle after acceptance. It returns only after the access (plus turnaround, for a read) has completed.
- R8: When not accessing, the bus is parked. The two selects always carry opposite levels, and while deselected, write enable, output enable and the drivers are all inactive.
- R9: While `retain_req` is 1, `req_ready` is 0 and requests have no effect on the pins or the memory contents. After release, `req_ready` stays 0 for cycle time + 1 cycles, counted from the release cycle.
- R10: A `retain_req` raised during an access lets that access finish with full timing before the bus parks.
- R11: `mem_dq_oe`=1 and `mem_oe_n`=0 never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retain_req | input | 1 | Park the bus and hold off requests for data retention |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Read data |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 8 | Data from the memory pads |

## Verification
Some pin relations are checked on every cycle: no cycle drives the data pads while output enable is low, the selects stay complementary, and a deselected bus is quiet. Write-enable width, address and data stability under write enable, the turnaround before the drivers turn on, the single-cycle read strobe and the retention hold-off are checked every cycle as well. Other properties only the bench's scenarios can show: that the exact pulse and cycle counts come from the ceiling arithmetic, that written bytes at the address extremes read back intact, that a request during retention leaves memory contents unchanged, and that an access interrupted by retention still completes.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_TURN,
    ST_RETAIN,
    ST_RECOVER
  } seq_state_t;

  typedef enum logic [2:0] {
    T_CYCLE,
    T_WPULSE,
    T_DOVL,
    T_SELEND,
    T_ACC,
    T_OEACC,
    T_HZ
  } tkind_t;

  typedef struct packed {
    logic sel;
    logic wr_pulse;
    logic rd_en;
    logic drive;
  } pin_ctl_t;

  // ceiling division, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // nanosecond figures per speed grade: 0 fastest, 1 middle, 2 slowest
  function automatic int unsigned grade_ns(input int unsigned grade, input tkind_t k);
    int unsigned v;
    case (k)
      T_CYCLE:  v = (grade == 0) ? 55 : (grade == 1) ? 70 : 85;
      T_WPULSE: v = (grade == 0) ? 40 : (grade == 1) ? 50 : 55;
      T_DOVL:   v = (grade == 0) ? 25 : (grade == 1) ? 30 : 40;
      T_SELEND: v = (grade == 0) ? 45 : (grade == 1) ? 60 : 70;
      T_ACC:    v = (grade == 0) ? 55 : (grade == 1) ? 70 : 85;
      T_OEACC:  v = (grade == 0) ? 25 : (grade == 1) ? 35 : 45;
      T_HZ:     v = (grade == 0) ? 20 : (grade == 1) ? 25 : 30;
      default:  v = 85;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_LEN  = 7,
  parameter int unsigned WR_LEN  = 7,
  parameter int unsigned WP_LEN  = 6,
  parameter int unsigned HZ_LEN  = 3,
  parameter int unsigned REC_LEN = 7,
  parameter int unsigned CW      = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     retain_req,
  input  logic     req_valid,
  input  logic     req_write,
  output logic     req_ready,
  output logic     accept_evt,
  output logic     cap_evt,
  output pin_ctl_t ctl_nxt
);

  seq_state_t    state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  assign req_ready  = (state == ST_IDLE) && !retain_req;
  assign accept_evt = req_ready && req_valid;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt + 1'b1;
    cap_evt   = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (retain_req)      state_nxt = ST_RETAIN;
        else if (accept_evt) state_nxt = req_write ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        if (cnt == CW'(RD_LEN - 1)) begin
          state_nxt = ST_TURN;
          cnt_nxt   = '0;
          cap_evt   = 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == CW'(HZ_LEN - 1)) begin
          state_nxt = retain_req ? ST_RETAIN : ST_IDLE;
          cnt_nxt   = '0;
        end
      end
      ST_WRITE: begin
        if (cnt == CW'(WR_LEN - 1)) begin
          state_nxt = retain_req ? ST_RETAIN : ST_IDLE;
          cnt_nxt   = '0;
        end
      end
      ST_RETAIN: begin
        cnt_nxt = '0;
        if (!retain_req) state_nxt = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (retain_req) begin
          state_nxt = ST_RETAIN;
          cnt_nxt   = '0;
        end else if (cnt == CW'(REC_LEN - 1)) begin
          state_nxt = ST_IDLE;
          cnt_nxt   = '0;
        end
      end
      default: begin
        state_nxt = ST_RETAIN;
        cnt_nxt   = '0;
      end
    endcase
  end

  // pin levels for the next cycle, registered by the pin stage
  always_comb begin
    ctl_nxt.sel      = (state_nxt == ST_READ) || (state_nxt == ST_WRITE);
    ctl_nxt.wr_pulse = (state_nxt == ST_WRITE) && (cnt_nxt < CW'(WP_LEN));
    ctl_nxt.rd_en    = (state_nxt == ST_READ);
    ctl_nxt.drive    = (state_nxt == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RECOVER;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/sram_pins.sv
`timescale 1ns/1ps
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pin_ctl_t      ctl_nxt,
  input  logic          accept_evt,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);

  // every pin leaves a flop so the asynchronous part never sees a decode glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= !ctl_nxt.sel;
      mem_cs    <= ctl_nxt.sel;
      mem_we_n  <= !ctl_nxt.wr_pulse;
      mem_oe_n  <= !ctl_nxt.rd_en;
      mem_dq_oe <= ctl_nxt.drive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept_evt) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_rdcap.sv
`timescale 1ns/1ps
module sram_rdcap #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_evt,
  input  logic [DW-1:0] mem_dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_evt;
      if (cap_evt) rsp_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned GRADE  = 0,
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retain_req,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int unsigned TRC_CYC = ns_to_cyc(grade_ns(GRADE, T_CYCLE), CLK_NS);
  localparam int unsigned WP_CYC  = max2(max2(ns_to_cyc(grade_ns(GRADE, T_WPULSE), CLK_NS),
                                              ns_to_cyc(grade_ns(GRADE, T_SELEND), CLK_NS)),
                                         ns_to_cyc(grade_ns(GRADE, T_DOVL), CLK_NS));
  localparam int unsigned ACC_CYC = max2(ns_to_cyc(grade_ns(GRADE, T_ACC), CLK_NS),
                                         ns_to_cyc(grade_ns(GRADE, T_OEACC), CLK_NS));
  localparam int unsigned HZ_CYC  = ns_to_cyc(grade_ns(GRADE, T_HZ), CLK_NS);
  localparam int unsigned RD_LEN  = max2(ACC_CYC, TRC_CYC);
  localparam int unsigned WR_LEN  = max2(TRC_CYC, WP_CYC + 1);
  localparam int unsigned CNT_MAX = max2(max2(RD_LEN, WR_LEN), HZ_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic     accept_evt;
  logic     cap_evt;
  pin_ctl_t ctl_nxt;

  sram_seq #(
    .RD_LEN (RD_LEN),
    .WR_LEN (WR_LEN),
    .WP_LEN (WP_CYC),
    .HZ_LEN (HZ_CYC),
    .REC_LEN(TRC_CYC),
    .CW     (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .retain_req(retain_req),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept_evt(accept_evt),
    .cap_evt   (cap_evt),
    .ctl_nxt   (ctl_nxt)
  );

  sram_pins #(
    .AW(AW),
    .DW(DW)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_nxt   (ctl_nxt),
    .accept_evt(accept_evt),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_rdcap #(
    .DW(DW)
  ) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_evt  (cap_evt),
    .mem_dq_in(mem_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int unsigned WP_C = 6,
  parameter int unsigned HZ_C = 3,
  parameter int unsigned AW   = 17,
  parameter int unsigned DW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retain_req,
  input logic          req_ready,
  input logic          accept_evt,
  input logic          rsp_valid,
  input logic          mem_cs_n,
  input logic          mem_cs,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);

  logic [7:0] we_run;
  logic [7:0] oe_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run  <= '0;
      oe_idle <= 8'hFF;
    end else begin
      if (!mem_we_n) we_run <= (we_run == 8'hFF) ? we_run : we_run + 8'd1;
      else           we_run <= '0;
      if (!mem_oe_n) oe_idle <= '0;
      else           oe_idle <= (oe_idle == 8'hFF) ? oe_idle : oe_idle + 8'd1;
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R11

  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n != mem_cs); // R8

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe)); // R8

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 8'(WP_C))); // R5

  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R5

  AST_WE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_idle >= 8'(HZ_C))); // R6

  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R4

  AST_RETAIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    retain_req |-> !req_ready); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready); // R7

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .WP_C(WP_CYC),
  .HZ_C(HZ_CYC),
  .AW  (AW),
  .DW  (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .retain_req(retain_req),
  .req_ready (req_ready),
  .accept_evt(accept_evt),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_cs    (mem_cs),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // grade 0 at 8 ns, restated from the requirements
  localparam int E_TRC   = cdiv(55, 8);
  localparam int E_WP    = imax(imax(cdiv(40, 8), cdiv(45, 8)), cdiv(25, 8));
  localparam int E_ACC   = imax(cdiv(55, 8), cdiv(25, 8));
  localparam int E_HZ    = cdiv(20, 8);
  localparam int E_RDLEN = imax(E_ACC, E_TRC);
  localparam int E_WRLEN = imax(E_TRC, E_WP + 1);

  // {write, addr[16:0], data[7:0]}; for reads the data field is the expected byte
  localparam logic [25:0] VECS [10] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h10001, 8'hFF},
    {1'b1, 17'h000FE, 8'h00},
    {1'b0, 17'h00000, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h00005, 8'h81},
    {1'b0, 17'h10001, 8'hFF},
    {1'b0, 17'h000FE, 8'h00},
    {1'b0, 17'h00005, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retain_req = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [7:0] model [256];

  always #4 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .retain_req(retain_req),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

  // simple memory model: stores while selected with write enable low
  always @(negedge clk) begin
    if (!mem_cs_n && mem_cs && !mem_we_n) model[mem_addr[7:0]] <= mem_dq_out;
  end
  assign mem_dq_in = (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n) ? model[mem_addr[7:0]] : 8'hEE;

  function automatic bit parked();
    return mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
      finish_run();
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic run_vec(input logic [25:0] v);
    logic        wr;
    logic [16:0] a;
    logic [7:0]  d;
    int busy, we_lo, oe_lo, drv, rsp_cnt, rsp_at, addr_bad, data_bad;
    logic [7:0] rsp_v;
    wr = v[25]; a = v[24:8]; d = v[7:0];
    busy = 0; we_lo = 0; oe_lo = 0; drv = 0; rsp_cnt = 0; rsp_at = 0;
    addr_bad = 0; data_bad = 0; rsp_v = '0;
    wait_ready();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) begin
        drv++;
        if (mem_dq_out != d) data_bad++;
      end
      if (!mem_cs_n && mem_addr != a) addr_bad++;
      if (rsp_valid) begin rsp_cnt++; rsp_at = k; rsp_v = rsp_data; end
      if (req_ready) break;
      busy++;
      @(negedge clk);
    end
    chk(addr_bad == 0, "R3", "address on bus while selected", addr_bad, 0);
    if (wr) begin
      chk(busy == E_WRLEN, "R7", "write busy cycles", busy, E_WRLEN);
      chk(we_lo == E_WP, "R2", "write pulse cycles", we_lo, E_WP);
      chk(oe_lo == 0, "R5", "output enable low during write", oe_lo, 0);
      chk(drv == E_WRLEN, "R5", "driver cycles during write", drv, E_WRLEN);
      chk(data_bad == 0, "R5", "driven data mismatches", data_bad, 0);
      chk(rsp_cnt == 0, "R4", "strobes during write", rsp_cnt, 0);
    end else begin
      chk(busy == E_RDLEN + E_HZ, "R6", "read busy cycles incl turnaround", busy, E_RDLEN + E_HZ);
      chk(oe_lo == E_RDLEN, "R3", "output enable cycles", oe_lo, E_RDLEN);
      chk(we_lo == 0 && drv == 0, "R3", "write or drive during read", we_lo + drv, 0);
      chk(rsp_cnt == 1, "R4", "read strobes", rsp_cnt, 1);
      chk(rsp_at == E_RDLEN + 1, "R4", "strobe position", rsp_at, E_RDLEN + 1);
      chk(rsp_v == d, "R4", "read data", int'(rsp_v), int'(d));
    end
  endtask

  initial begin
    int cnt;
    // reset state, R1
    repeat (3) @(negedge clk);
    chk(parked(), "R1", "pins parked in reset", int'(parked()), 1);
    chk(!rsp_valid && !req_ready, "R1", "strobe/ready in reset", int'(rsp_valid) + int'(req_ready), 0);
    rst_n = 1'b1;
    cnt = 0;
    while (!req_ready && cnt < 50) begin
      cnt++;
      chk(parked(), "R8", "pins parked during recovery", int'(parked()), 1);
      @(negedge clk);
    end
    chk(cnt == E_TRC, "R1", "ready hold-off after reset", cnt, E_TRC);
    chk(parked() && !rsp_valid, "R8", "idle bus parked", int'(parked()), 1);

    // vector table
    for (int i = 0; i < 10; i++) run_vec(VECS[i]);

    // R9: requests ignored while retention is held
    @(negedge clk);
    retain_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'h77;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!req_ready, "R9", "ready during retention", int'(req_ready), 0);
      chk(parked(), "R9", "pins parked during retention", int'(parked()), 1);
    end
    req_valid = 1'b0;
    retain_req = 1'b0;
    cnt = 0;
    while (!req_ready && cnt < 50) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == E_TRC + 1, "R9", "ready hold-off after retention", cnt, E_TRC + 1);
    run_vec({1'b0, 17'h00000, 8'hA5});

    // R10: retention raised in the middle of a write
    begin
      int we_lo, drv, rdy;
      we_lo = 0; drv = 0; rdy = 0;
      wait_ready();
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'h5E;
      @(negedge clk);
      req_valid = 1'b0;
      retain_req = 1'b1;
      for (int k = 0; k < 20; k++) begin
        if (!mem_we_n) we_lo++;
        if (mem_dq_oe) drv++;
        if (req_ready) rdy++;
        @(negedge clk);
      end
      chk(we_lo == E_WP, "R10", "write pulse completed under retention", we_lo, E_WP);
      chk(drv == E_WRLEN, "R10", "write data phase completed", drv, E_WRLEN);
      chk(rdy == 0, "R9", "ready cycles while retained", rdy, 0);
      chk(parked(), "R10", "bus parked after finishing", int'(parked()), 1);
      retain_req = 1'b0;
      run_vec({1'b0, 17'h00042, 8'h5E});
    end

    finish_run();
  end

endmodule